// File: doc/BRIEF.md
# I2C Slave Register-Access Port

This block lets a host on an I2C bus read and write a bank of eight byte-wide registers. The registers themselves live outside the block. It oversamples SCL and SDA on the system clock and recognises START, repeated START and STOP conditions. It matches a fixed 7-bit device address. Data moves through a plain register-file port: a 3-bit index, a write strobe with write data, and a read strobe with read data.

A write transaction sends the device address with the direction bit clear, then a subaddress byte, then any number of data bytes. The register index comes from subaddress bits [5:3]. Every data byte of one burst is written to that same register, and the index does not advance.

A read transaction first sets the subaddress in the same way. A repeated START follows, then the device address again with the direction bit set. The selected register is shifted out once per byte until the host answers a byte with a NACK. SDA is only ever pulled low: the block drives an open-drain output enable and never drives a high level.

Top module: `i2c_regport`

## Requirements
- R1: During and right after reset, `sda_oe`, `reg_wr` and `reg_rd` are low.
- R2: The block pulls SDA low in the ninth clock of a matching address byte (address in bits [7:1], direction in bit 0), of the subaddress byte and of every written data byte.
- R3: `reg_addr` takes subaddress bits [5:3]. Subaddress bits [7:6] and [2:0] have no effect on which register is accessed.
- R4: Each written data byte, received MSB first, gives exactly one single-cycle `reg_wr` pulse carrying that byte. All bytes of one burst go to the same register index.
- R5: After a repeated START and the device address with bit 0 set, each byte sent is preceded by one `reg_rd` pulse. The byte is `reg_rdata` as seen in the cycle of that pulse, shifted out MSB first.
- R6: A host ACK after a read byte causes another byte to be sent. A host NACK makes the block release SDA and issue no further `reg_rd` until the next START.
- R7: A byte whose bits [7:1] differ from the device address is not acknowledged. After it, no strobe is issued and SDA stays released until the next START.
- R8: A START or STOP in the middle of a byte abandons that byte without a strobe. After a START, the next byte is treated as a new device address.
- R9: `sda_oe` changes only while the synchronised SCL is low, except when it is cleared by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | 3 | Register index taken from the subaddress |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Data byte that goes with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register contents, sampled in the `reg_rd` cycle |

## Verification
The hardest case to reach from the ports is a START or STOP that lands in the middle of a byte. It must leave no trace: no strobe, no stuck SDA driver and no half-filled shift register carried into the next byte. The bench reaches it by clocking only part of a subaddress byte and then issuing a repeated START, and separately by issuing STOP right after the subaddress. In both cases it follows with a complete, well-formed transaction whose result must be exact. The bench also sweeps every register index, with junk in the ignored subaddress bits, so that a register-index decode from the wrong bits shows up as a wrong register file state.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_SUB,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_RACK,
    S_WAIT
  } slv_state_t;

  // Address byte carries the 7-bit device address above the direction bit.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev);
  endfunction

  // Register index sits in subaddress bits [5:3].
  function automatic logic [2:0] reg_index(input logic [7:0] sub);
    return sub[5:3];
  endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[LAST];
      sda_q    <= sda_pipe[LAST];
    end
  end

  assign scl_s    = scl_pipe[LAST];
  assign sda_s    = sda_pipe[LAST];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  // R8: a bus condition is never seen on a cycle where SCL moves
  p_cond_scl_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> $past(scl_s) && scl_s);

endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         DW       = 8,
  parameter int         AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  slv_state_t    st, nxt_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] sel_q;
  logic          oe_q, more_q;

  // named internal events
  logic byte_done, wr_ev, rd_load;

  always_comb begin
    byte_done = scl_fall && (cnt == FULL);
    wr_ev     = byte_done && (st == S_WDATA);
    rd_load   = scl_fall && (((st == S_ACK) && (nxt_q == S_RDATA)) ||
                             ((st == S_RACK) && more_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nxt_q  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sel_q  <= '0;
      oe_q   <= 1'b0;
      more_q <= 1'b0;
    end else if (start_ev) begin
      st   <= S_ADDR;
      cnt  <= '0;
      oe_q <= 1'b0;
    end else if (stop_ev) begin
      st   <= S_IDLE;
      cnt  <= '0;
      oe_q <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_SUB, S_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == S_ADDR) begin
              if (addr_hit(sh, DEV_ADDR)) begin
                oe_q  <= 1'b1;
                st    <= S_ACK;
                nxt_q <= sh[0] ? S_RDATA : S_SUB;
              end else begin
                st <= S_WAIT;
              end
            end else begin
              if (st == S_SUB) sel_q <= reg_index(sh);
              oe_q  <= 1'b1;
              st    <= S_ACK;
              nxt_q <= S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (rd_load) begin
              sh   <= reg_rdata;
              oe_q <= ~reg_rdata[DW-1];
              cnt  <= '0;
              st   <= S_RDATA;
            end else begin
              oe_q <= 1'b0;
              st   <= nxt_q;
            end
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              oe_q <= 1'b0;
              st   <= S_RACK;
            end else begin
              sh   <= {sh[DW-2:0], 1'b0};
              oe_q <= ~sh[DW-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            more_q <= ~sda_s;
          end else if (scl_fall) begin
            if (rd_load) begin
              sh   <= reg_rdata;
              oe_q <= ~reg_rdata[DW-1];
              cnt  <= '0;
              st   <= S_RDATA;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = sel_q;
  assign reg_wr    = wr_ev;
  assign reg_wdata = sh;
  assign reg_rd    = rd_load;

  // R9: the SDA driver moves only while SCL is low, unless a bus condition cleared it
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

  // R2: a written byte is acknowledged in the following cycle
  p_wr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> sda_oe);

  // R5: the first bit driven is the MSB of the register read in the strobe cycle
  p_rd_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (sda_oe == !$past(reg_rdata[DW-1])));

  // R4: write and read strobes never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R7: while ignoring the bus the line is released
  p_wait_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !oe_q);

  // R8: a START restarts address matching with an empty byte
  p_start_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_ADDR) && (cnt == '0) && !oe_q);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_slave_ctl #(.DEV_ADDR(DEV_ADDR), .DW(8), .AW(3)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [8];
  logic [7:0] exp_mem [8];
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regport #(.DEV_ADDR(DEV)) u_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 8'(8'h13 * i + 8'h40);
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
    if (reg_wr) wr_cnt <= wr_cnt + 1;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic clk_bit(input logic b, output logic got);
    sda_m = b; waitq();
    scl = 1'b1; waitq();
    got = sda_line; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic d;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], d);
    clk_bit(1'b1, nack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, d);
      b[i] = d;
    end
    clk_bit(nack, d);
  endtask

  task automatic compare_mem(input string req);
    for (int i = 0; i < 8; i++)
      chk(mem[i] == exp_mem[i], req, int'(mem[i]), int'(exp_mem[i]));
  endtask

  initial begin
    logic nk;
    logic [7:0] rb;
    int w0, r0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!sda_oe, "R1 sda_oe in reset", int'(sda_oe), 0);
    chk(!reg_wr && !reg_rd, "R1 strobes in reset", int'({reg_wr, reg_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'(8'h13 * i + 8'h40);
    chk(!sda_oe && !reg_wr && !reg_rd, "R1 after reset", int'({sda_oe, reg_wr, reg_rd}), 0);
    waitq(2);

    // R2 R3 R4: write bursts to every index, junk in ignored subaddress bits
    for (int idx = 0; idx < 8; idx++) begin
      logic [7:0] sub, d0, d1;
      sub = {2'(idx + 1), 3'(idx), 3'(7 - idx)};
      d0  = 8'(8'hA5 ^ (idx * 8'h11));
      d1  = 8'(8'h3C + idx * 8'h07);
      w0  = wr_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, nk); chk(!nk, "R2 address ack", int'(nk), 0);
      send_byte(sub, nk);         chk(!nk, "R2 subaddress ack", int'(nk), 0);
      send_byte(d0, nk);          chk(!nk, "R2 data ack", int'(nk), 0);
      send_byte(d1, nk);          chk(!nk, "R2 second data ack", int'(nk), 0);
      bus_stop();
      exp_mem[idx] = d1;
      chk(wr_cnt - w0 == 2, "R4 one strobe per byte", wr_cnt - w0, 2);
      compare_mem("R3 R4 burst lands on selected register");
    end

    // R5 R6: reads from every index, three bytes, last NACKed
    for (int idx = 0; idx < 8; idx++) begin
      r0 = rd_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, nk);
      send_byte({2'b10, 3'(idx), 3'b011}, nk);
      bus_rstart();
      send_byte({DEV, 1'b1}, nk); chk(!nk, "R5 read address ack", int'(nk), 0);
      for (int k = 0; k < 3; k++) begin
        recv_byte(k == 2, rb);
        chk(rb == exp_mem[idx], "R5 read byte", int'(rb), int'(exp_mem[idx]));
      end
      waitq(2);
      chk(!sda_oe, "R6 released after NACK", int'(sda_oe), 0);
      chk(rd_cnt - r0 == 3, "R6 read strobes", rd_cnt - r0, 3);
      bus_stop();
    end

    // R7: wrong device address
    w0 = wr_cnt; r0 = rd_cnt;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, nk); chk(nk, "R7 no ack on mismatch", int'(nk), 1);
    send_byte(8'b00_010_000, nk);       chk(nk, "R7 subaddress ignored", int'(nk), 1);
    send_byte(8'h00, nk);               chk(nk, "R7 data ignored", int'(nk), 1);
    chk(!sda_oe, "R7 line released", int'(sda_oe), 0);
    bus_stop();
    send_byte(8'hFF, nk);
    chk(wr_cnt == w0 && rd_cnt == r0, "R7 no strobes", wr_cnt - w0, 0);
    compare_mem("R7 registers untouched");

    // R8: repeated START in the middle of the subaddress byte
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, nk);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, nk);
    bus_rstart();
    send_byte({DEV, 1'b0}, nk); chk(!nk, "R8 address after abort", int'(nk), 0);
    send_byte(8'b01_010_110, nk);
    send_byte(8'h5C, nk);       chk(!nk, "R8 data ack after abort", int'(nk), 0);
    bus_stop();
    exp_mem[2] = 8'h5C;
    chk(wr_cnt - w0 == 1, "R8 one write after abort", wr_cnt - w0, 1);
    compare_mem("R8 write after aborted byte");

    // R8: STOP right after the subaddress and mid data byte gives no write
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, nk);
    send_byte(8'b00_110_000, nk);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, nk);
    bus_stop();
    chk(wr_cnt == w0, "R8 STOP mid byte writes nothing", wr_cnt - w0, 0);
    chk(!sda_oe, "R8 released after STOP", int'(sda_oe), 0);
    compare_mem("R8 registers after STOP abort");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule